// File: doc/BRIEF.md
# Set-Associative Cache Directory with Tree Pseudo-LRU

This block holds the tag, valid, dirty and replacement state of a parameterised set-associative cache. It stores no line data. Each accepted request carries an address and a write flag. The block splits the address into tag, set and offset fields. It searches every way of the addressed set in the same cycle. It then reports what the access did to the set: a hit, a fill into an empty way, a clean eviction, or an eviction of a dirty line. It also reports the way that was used.

Replacement follows a binary tree of WAYS-1 bits per set, stored in heap order. An access to a way turns the bits on its path to point away from that way. When every way is valid, walking the bits from the root gives the victim. Three command inputs act on the whole directory: flush clears every dirty bit, invalidate clears every valid bit, and a replacement clear zeroes every tree bit. A cache controller uses the outcome code to decide whether a refill, a writeback, or both must follow.

Top module: `cache_dir`

## Requirements
- R1: The address splits, from the MSB down, into a TAG_W-bit tag, then a log2(SETS)-bit set index, then the offset. The offset takes no part in lookup. With the defaults, 0xABCD has tag 0xAB and set 0xC.
- R2: A hit is a valid way of the set whose tag matches. A hit reports code 0 and that way, sets the line's dirty bit to its old value OR the write flag, and updates the tree for that way. At most one way of a set ever hits.
- R3: On a miss in a set that has an invalid way, the lowest-numbered invalid way is filled: the new tag is written, valid is set, and dirty takes the write flag. The code is 1 and the tree is updated for that way.
- R4: On a miss with all ways valid, the tree victim is replaced by the new tag, with dirty set to the write flag. The code is 3 if the replaced line was dirty and 2 if it was clean. The tree is updated for the victim.
- R5: Tree update for way w: the bottom-row node (w/2 + (WAYS-1)/2) becomes 1 for even w and 0 for odd w. Walking upward, each parent becomes 1 when the child just left has an odd index, and 0 otherwise. Node i has children 2i+1 and 2i+2.
- R6: Victim walk: start at node 0, go to the left child on 0 and the right child on 1 until the bottom row is reached. The victim is 2*(node-(WAYS-1)/2) plus that node's bit. On set 0xC of a 4-way directory, this sequence applies: fills of ways 0..3, a write hit on way 0, a hit on way 2, then three new tags. The three new tags evict way 1 (code 2), way 3 (code 2) and way 0 (code 3), in that order.
- R7: A request is accepted when req_valid_i is high and no command input is high. resp_valid_o is high in the cycle after an accepted request, with resp_code_o and resp_way_o for it. It is low otherwise.
- R8: Flush clears every dirty bit and leaves valid bits and tags unchanged.
- R9: Invalidate clears every valid bit.
- R10: Replacement clear zeroes every tree bit, so a full set then evicts way 0.
- R11: A request that coincides with flush, invalidate or replacement clear is ignored. It produces no response and changes no tag, valid, dirty or tree state.
- R12: Reset (rst_ni low, asynchronous) clears all valid, dirty and tree bits and drives resp_valid_o low.
- R13: With WAYS=1 there is no tree. The single way is always the victim, so a new tag reports code 2 or 3 on way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Access request |
| req_addr_i | input | ADDR_W | Access address |
| req_write_i | input | 1 | Access is a write |
| flush_i | input | 1 | Clear all dirty bits |
| inval_i | input | 1 | Clear all valid bits |
| plru_clr_i | input | 1 | Clear all replacement bits |
| resp_valid_o | output | 1 | Response for the request of the previous cycle |
| resp_code_o | output | 2 | 0 hit, 1 fill, 2 clean eviction, 3 dirty eviction |
| resp_way_o | output | max(1,log2(WAYS)) | Way hit or written |

## Verification
The assertions check the following on every cycle:
- a response follows exactly the accepted requests;
- no set ever holds two matching valid tags;
- a miss in a set that is not full reports a fill;
- each whole-directory command leaves its state bits at zero.

Which way the tree picks, and whether an eviction is clean or dirty, depend on the history of the set. Only the bench can show these. It runs the fixed 4-way eviction sequence. It runs flush, invalidate and clear interleaved with accesses, including commands that arrive in the same cycle as a request. It also runs a single-way instance, and a random stream compared against a behavioural model.

// File: rtl/cache_dir_pkg.sv
package cache_dir_pkg;
  typedef enum logic [1:0] {
    OUT_HIT         = 2'd0,
    OUT_FILL        = 2'd1,
    OUT_EVICT       = 2'd2,
    OUT_EVICT_DIRTY = 2'd3
  } outcome_e;
endpackage

// File: rtl/cd_tag_match.sv
module cd_tag_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [WAYS-1:0]            valid_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic [WAYS-1:0]            hit_vec_o,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           hit_way_o,
  output logic                       all_valid_o,
  output logic [WAY_W-1:0]           free_way_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec_o[w] = valid_i[w] && (tags_i[w] == tag_i);
  end

  assign hit_o       = |hit_vec_o;
  assign all_valid_o = &valid_i;

  // downward scan: lowest index wins
  always_comb begin
    hit_way_o  = '0;
    free_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec_o[w]) hit_way_o  = WAY_W'(w);
      if (!valid_i[w])  free_way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/cd_plru_update.sv
module cd_plru_update #(
  parameter int WAYS = 4,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int TREE_W = (WAYS > 1) ? WAYS - 1 : 1
) (
  input  logic [TREE_W-1:0] tree_i,
  input  logic [WAY_W-1:0]  way_i,
  output logic [TREE_W-1:0] tree_o
);
  if (WAYS == 1) begin : g_none
    assign tree_o = tree_i;
  end else begin : g_tree
    localparam int LEVELS = $clog2(WAYS);
    // node at depth d, position p covers ways p*2^(LEVELS-d) ..; on path -> point to other half
    for (genvar d = 0; d < LEVELS; d++) begin : g_lvl
      for (genvar p = 0; p < (1 << d); p++) begin : g_node
        localparam int NODE = (1 << d) - 1 + p;
        logic on_path;
        assign on_path      = (way_i >> (LEVELS - d)) == WAY_W'(p);
        assign tree_o[NODE] = on_path ? ~way_i[LEVELS-d-1] : tree_i[NODE];
      end
    end
  end
endmodule

// File: rtl/cd_plru_victim.sv
module cd_plru_victim #(
  parameter int WAYS = 4,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int TREE_W = (WAYS > 1) ? WAYS - 1 : 1
) (
  input  logic [TREE_W-1:0] tree_i,
  output logic [WAY_W-1:0]  victim_o
);
  if (WAYS == 1) begin : g_none
    assign victim_o = '0;
  end else begin : g_tree
    localparam int LEVELS = $clog2(WAYS);
    logic [LEVELS:0][WAY_W-1:0] path;
    assign path[0] = '0;
    // each level appends one victim bit, MSB first
    for (genvar d = 0; d < LEVELS; d++) begin : g_lvl
      logic [(1<<d)-1:0] pick;
      for (genvar p = 0; p < (1 << d); p++) begin : g_node
        assign pick[p] = tree_i[(1<<d)-1+p] && ((path[d] >> (LEVELS - d)) == WAY_W'(p));
      end
      assign path[d+1] = path[d] | (WAY_W'(|pick) << (LEVELS - 1 - d));
    end
    assign victim_o = path[LEVELS];
  end
endmodule

// File: rtl/cache_dir.sv
module cache_dir
  import cache_dir_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int TAG_W  = 8,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic              flush_i,
  input  logic              inval_i,
  input  logic              plru_clr_i,
  output logic              resp_valid_o,
  output logic [1:0]        resp_code_o,
  output logic [WAY_W-1:0]  resp_way_o
);
  localparam int SET_W  = $clog2(SETS);
  localparam int OFF_W  = ADDR_W - TAG_W - SET_W;
  localparam int TREE_W = (WAYS > 1) ? WAYS - 1 : 1;

  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
  logic [SETS-1:0][WAYS-1:0]            valid_q, dirty_q;
  logic [SETS-1:0][TREE_W-1:0]          tree_q;

  logic [TAG_W-1:0] req_tag;
  logic [SET_W-1:0] req_set;
  logic             cmd, acc;

  assign req_tag = req_addr_i[ADDR_W-1 -: TAG_W];
  assign req_set = req_addr_i[OFF_W +: SET_W];
  assign cmd     = flush_i | inval_i | plru_clr_i;
  assign acc     = req_valid_i & ~cmd;

  logic [WAYS-1:0]  hit_vec;
  logic             hit, all_valid;
  logic [WAY_W-1:0] hit_way, free_way, victim, sel_way;
  logic [TREE_W-1:0] tree_nxt;
  logic [WAYS-1:0]  set_dirty;
  outcome_e         outcome;

  assign set_dirty = dirty_q[req_set];

  cd_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .tags_i      (tag_q[req_set]),
    .valid_i     (valid_q[req_set]),
    .tag_i       (req_tag),
    .hit_vec_o   (hit_vec),
    .hit_o       (hit),
    .hit_way_o   (hit_way),
    .all_valid_o (all_valid),
    .free_way_o  (free_way)
  );

  cd_plru_victim #(.WAYS(WAYS)) u_victim (
    .tree_i   (tree_q[req_set]),
    .victim_o (victim)
  );

  always_comb begin
    if (hit) begin
      sel_way = hit_way;
      outcome = OUT_HIT;
    end else if (!all_valid) begin
      sel_way = free_way;
      outcome = OUT_FILL;
    end else begin
      sel_way = victim;
      outcome = set_dirty[victim] ? OUT_EVICT_DIRTY : OUT_EVICT;
    end
  end

  cd_plru_update #(.WAYS(WAYS)) u_update (
    .tree_i (tree_q[req_set]),
    .way_i  (sel_way),
    .tree_o (tree_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q        <= '0;
      valid_q      <= '0;
      dirty_q      <= '0;
      tree_q       <= '0;
      resp_valid_o <= 1'b0;
      resp_code_o  <= '0;
      resp_way_o   <= '0;
    end else begin
      resp_valid_o <= acc;
      if (acc) begin
        resp_code_o                <= outcome;
        resp_way_o                 <= sel_way;
        tag_q[req_set][sel_way]    <= req_tag;
        valid_q[req_set][sel_way]  <= 1'b1;
        dirty_q[req_set][sel_way]  <= req_write_i | (hit & set_dirty[sel_way]);
        tree_q[req_set]            <= tree_nxt;
      end
      // commands win over any access (acc is low then)
      if (flush_i)    dirty_q <= '0;
      if (inval_i)    valid_q <= '0;
      if (plru_clr_i) tree_q  <= '0;
    end
  end

  assert_resp_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> resp_valid_o);
  assert_resp_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !resp_valid_o);
  assert_cmd_blocks_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cmd) |=> !resp_valid_o);
  assert_hit_unique_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> $onehot0(hit_vec));
  assert_fill_not_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !hit && !all_valid) |=> resp_code_o == 2'd1);
  assert_flush_dirty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> dirty_q == '0);
  assert_inval_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i |=> valid_q == '0);
  assert_clr_tree_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plru_clr_i |=> tree_q == '0);
endmodule

// File: tb/tb_cache_dir.sv
`timescale 1ns/1ps
module tb_cache_dir;
  localparam int ADDR_W = 16;
  localparam int TAG_W  = 8;
  localparam int SETS   = 16;
  localparam int WAYS   = 4;
  localparam int SET_W  = $clog2(SETS);
  localparam int OFF_W  = ADDR_W - TAG_W - SET_W;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TW     = (WAYS > 1) ? WAYS - 1 : 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, flush = 1'b0, inval = 1'b0, pclr = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              resp_valid, r1_valid;
  logic [1:0]        resp_code, r1_code;
  logic [WAY_W-1:0]  resp_way;
  logic              r1_way;

  always #2.5 clk = ~clk;

  cache_dir #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .SETS(SETS), .WAYS(WAYS)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_write_i(req_write), .flush_i(flush), .inval_i(inval), .plru_clr_i(pclr),
    .resp_valid_o(resp_valid), .resp_code_o(resp_code), .resp_way_o(resp_way));

  cache_dir #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .SETS(SETS), .WAYS(1)) dut1 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_write_i(req_write), .flush_i(flush), .inval_i(inval), .plru_clr_i(pclr),
    .resp_valid_o(r1_valid), .resp_code_o(r1_code), .resp_way_o(r1_way));

  int n_chk = 0, n_err = 0;

  // behavioural reference for the WAYS-way instance
  int m_tag  [SETS][WAYS];
  bit m_val  [SETS][WAYS];
  bit m_dirt [SETS][WAYS];
  int m_tree [SETS][TW];

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic m_reset();
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        m_val[s][w] = 0; m_dirt[s][w] = 0; m_tag[s][w] = 0;
      end
      for (int n = 0; n < TW; n++) m_tree[s][n] = 0;
    end
  endtask

  task automatic m_touch(input int s, input int w);
    int bottom, idx, par;
    if (WAYS == 1) return;
    bottom = (WAYS - 1) / 2;
    idx = w / 2 + bottom;
    m_tree[s][idx] = (w % 2 == 0) ? 1 : 0;
    while (idx > 0) begin
      par = (idx - 1) / 2;
      m_tree[s][par] = idx % 2;
      idx = par;
    end
  endtask

  function automatic int m_victim(input int s);
    int bottom, idx;
    if (WAYS == 1) return 0;
    bottom = (WAYS - 1) / 2;
    idx = 0;
    while (idx < bottom) idx = (m_tree[s][idx] != 0) ? 2 * idx + 2 : 2 * idx + 1;
    return (idx - bottom) * 2 + m_tree[s][idx];
  endfunction

  task automatic m_access(input logic [ADDR_W-1:0] a, input bit wr, output int code, output int way);
    int t, s, v;
    t = int'(a) / (1 << (ADDR_W - TAG_W));
    s = (int'(a) / (1 << OFF_W)) % SETS;
    for (int w = 0; w < WAYS; w++)
      if (m_val[s][w] && m_tag[s][w] == t) begin
        m_dirt[s][w] = m_dirt[s][w] | wr;
        m_touch(s, w);
        code = 0; way = w;
        return;
      end
    for (int w = 0; w < WAYS; w++)
      if (!m_val[s][w]) begin
        m_tag[s][w] = t; m_val[s][w] = 1; m_dirt[s][w] = wr;
        m_touch(s, w);
        code = 1; way = w;
        return;
      end
    v = m_victim(s);
    code = m_dirt[s][v] ? 3 : 2;
    m_tag[s][v] = t; m_dirt[s][v] = wr;
    m_touch(s, v);
    way = v;
  endtask

  // one clock: drive at negedge, sample 1 ns after posedge; ec/ew/e1 < 0 skip fixed expectation
  task automatic step(input bit rv, input logic [ADDR_W-1:0] a, input bit wr,
                      input bit fl, input bit iv, input bit cl,
                      input int ec, input int ew, input int e1, input string req);
    int mc, mw;
    bit ev;
    req_valid = rv; req_addr = a; req_write = wr; flush = fl; inval = iv; pclr = cl;
    ev = rv && !(fl || iv || cl);
    mc = 0; mw = 0;
    if (ev) m_access(a, wr, mc, mw);
    if (fl) for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) m_dirt[s][w] = 0;
    if (iv) for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) m_val[s][w] = 0;
    if (cl) for (int s = 0; s < SETS; s++) for (int n = 0; n < TW; n++) m_tree[s][n] = 0;
    @(posedge clk);
    #1;
    chk({req, " resp_valid (R7)"}, int'(resp_valid), int'(ev));
    if (ev) begin
      chk({req, " model code"}, int'(resp_code), mc);
      chk({req, " model way"}, int'(resp_way), mw);
      if (ec >= 0) chk({req, " code"}, int'(resp_code), ec);
      if (ew >= 0) chk({req, " way"}, int'(resp_way), ew);
      if (e1 >= 0) begin
        chk({req, " 1-way code (R13)"}, int'(r1_code), e1);
        chk({req, " 1-way way (R13)"}, int'(r1_way), 0);
      end
    end
    @(negedge clk);
  endtask

  function automatic logic [ADDR_W-1:0] mk(input int t, input int s, input int o);
    return ADDR_W'((t << (ADDR_W - TAG_W)) | (s << OFF_W) | o);
  endfunction

  task automatic idle();
    step(0, '0, 0, 0, 0, 0, -1, -1, -1, "idle");
  endtask

  bit timed_out = 0;

  initial begin
    #(5.0 * 200000);
    timed_out = 1;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    chk("R12 resp_valid in reset", int'(resp_valid), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R13 single-way instance on set 3 (main instance follows the model)
    step(1, mk(8'hA1, 3, 0), 0, 0, 0, 0, 1, 0, 1, "R13 fill");
    step(1, mk(8'hA2, 3, 0), 1, 0, 0, 0, -1, -1, 2, "R13 clean evict");
    step(1, mk(8'hA3, 3, 0), 0, 0, 0, 0, -1, -1, 3, "R13 dirty evict");
    step(1, mk(8'hA3, 3, 5), 0, 0, 0, 0, -1, -1, 0, "R13 hit");

    // R1 split: same tag/set, different offset hits; other tag misses
    step(1, 16'h12C5, 0, 0, 0, 0, 1, 0, -1, "R1 first");
    step(1, 16'h12CA, 0, 0, 0, 0, 0, 0, -1, "R1 offset ignored");
    step(1, 16'h13CA, 0, 0, 0, 0, 1, 1, -1, "R1 tag differs");
    step(0, '0, 0, 0, 1, 0, -1, -1, -1, "R9 inval");
    step(0, '0, 0, 0, 0, 1, -1, -1, -1, "R10 clear");

    // R5/R6 fixed sequence on set 0xC
    step(1, mk(1, 12, 0), 0, 0, 0, 0, 1, 0, -1, "R3 fill w0");
    step(1, mk(1, 12, 0), 0, 0, 0, 0, 0, 0, -1, "R2 repeat hit");
    step(1, mk(2, 12, 0), 0, 0, 0, 0, 1, 1, -1, "R3 fill w1");
    step(1, mk(3, 12, 0), 0, 0, 0, 0, 1, 2, -1, "R3 fill w2");
    step(1, mk(4, 12, 0), 0, 0, 0, 0, 1, 3, -1, "R3 fill w3");
    idle();
    step(1, mk(1, 12, 0), 1, 0, 0, 0, 0, 0, -1, "R2 write hit w0");
    step(1, mk(3, 12, 0), 0, 0, 0, 0, 0, 2, -1, "R5 hit w2");
    step(1, mk(5, 12, 0), 0, 0, 0, 0, 2, 1, -1, "R6 evict w1");
    step(1, mk(6, 12, 0), 0, 0, 0, 0, 2, 3, -1, "R6 evict w3");
    step(1, mk(7, 12, 0), 0, 0, 0, 0, 3, 0, -1, "R4 dirty evict w0");

    // R8 flush
    step(1, mk(5, 12, 0), 1, 0, 0, 0, 0, 1, -1, "R2 dirty w1");
    step(0, '0, 0, 1, 0, 0, -1, -1, -1, "R8 flush");
    step(1, mk(5, 12, 0), 0, 0, 0, 0, 0, 1, -1, "R8 valid kept");
    step(1, mk(8, 12, 0), 0, 0, 0, 0, 2, 2, -1, "R6 evict w2");
    step(1, mk(9, 12, 0), 0, 0, 0, 0, 2, 0, -1, "R6 evict w0");
    step(1, mk(10, 12, 0), 0, 0, 0, 0, 2, 3, -1, "R6 evict w3");
    step(1, mk(11, 12, 0), 0, 0, 0, 0, 2, 1, -1, "R8 flushed line clean");

    // R10 clear then full set evicts way 0
    step(0, '0, 0, 0, 0, 1, -1, -1, -1, "R10 clear");
    step(1, mk(12, 12, 0), 0, 0, 0, 0, 2, 0, -1, "R10 victim w0");

    // R9 invalidate
    step(0, '0, 0, 0, 1, 0, -1, -1, -1, "R9 inval");
    step(1, mk(12, 12, 0), 0, 0, 0, 0, 1, 0, -1, "R9 refill after inval");

    // R11 access with command is ignored
    step(1, mk(8'h20, 12, 0), 1, 1, 0, 0, -1, -1, -1, "R11 access+flush");
    step(1, mk(8'h20, 12, 0), 0, 0, 0, 0, 1, 1, -1, "R11 not filled");
    step(1, mk(8'h21, 12, 0), 1, 0, 0, 1, -1, -1, -1, "R11 access+clear");
    step(1, mk(8'h21, 12, 0), 0, 0, 0, 0, 1, 2, -1, "R11 not filled 2");

    // random stream against the model
    for (int i = 0; i < 600; i++) begin
      int rv, fl, iv, cl;
      rv = ($urandom % 10) < 8;
      fl = ($urandom % 40) == 0;
      iv = ($urandom % 60) == 0;
      cl = ($urandom % 40) == 0;
      step(rv[0], mk(1 + $urandom % 6, $urandom % 4, $urandom % 16), 1'($urandom % 2),
           fl[0], iv[0], cl[0], -1, -1, -1, "R2-R11 random");
    end

    // R12 reset mid-run
    rst_ni = 1'b0;
    #1;
    chk("R12 resp_valid async reset", int'(resp_valid), 0);
    m_reset();
    @(negedge clk);
    rst_ni = 1'b1;
    step(1, mk(1, 2, 0), 0, 0, 0, 0, 1, 0, -1, "R12 empty after reset");
    step(1, mk(1, 2, 0), 0, 0, 0, 0, 0, 0, -1, "R12 hit after refill");

    if (!timed_out) begin
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule